// File: doc/BRIEF.md
# Burst Column Sequencer with Mode Word Decode

This block holds the operating mode of a double-data-rate memory device and turns every column command into the column addresses that the burst visits. A mode word is loaded through a strobe. The block decodes the burst length, the burst ordering and the read latency from that word. It accepts the word only when every field holds a supported value. When the word is refused, the error flag goes up and the mode already in force stays as it was.

A column command gives a starting column and an auto-precharge bit. From that point the block emits one column address per clock. Each address is the first column of a pair of data beats, so a burst of length BL occupies BL/2 cycles. The burst-active and last-beat flags frame the burst. Sequential ordering wraps inside the aligned burst block. Interleaved ordering XORs the beat offset into the low column bits. A full-page burst walks all columns in a ring until a terminate request or a new column command arrives.

Top module: `burst_col_sequencer`

## Requirements
- R1: After a synchronous active-low reset, the mode is burst length 2, sequential, read latency 3. The outputs are `mode_error`=0, `dll_reset`=0, `burst_active`=0, `burst_reject`=0 and `col_addr`=0.
- R2: A load whose word is legal takes effect on the next clock edge. Word bits [2:0] select the burst length (001=2, 010=4, 011=8, 111=full page). Bit 3 selects the ordering (0 sequential, 1 interleaved). Bits [6:4] give the read latency, which appears on `read_latency`. An accepted load clears `mode_error`.
- R3: A load is refused, `mode_error` rises one cycle later and the previous mode is kept, in any of these cases: a length code outside the four legal codes, a latency other than 3 or 4, bit 7 high, any of bits [11:9] high, or a nonzero `mode_bank`.
- R4: A word that selects a full-page burst together with interleaved ordering is refused, in the same way as in R3.
- R5: An accepted word with bit 8 high raises `dll_reset` for exactly one cycle, in the cycle after the load. The other fields of that word are applied.
- R6: A burst of length BL gives BL/2 consecutive cycles with `burst_active`=1. `burst_last` is high on the final one only, and `burst_active` falls in the cycle after that.
- R7: In sequential ordering, the address of pair i is the start column with its low log2(BL) bits replaced by (start + 2i) mod BL. The upper bits stay fixed.
- R8: In interleaved ordering, the address of pair i is the start column with 2i XORed into its low log2(BL) bits.
- R9: A full-page burst adds 2 per cycle modulo 256, never raises `burst_last`, and ends one cycle after `burst_halt`.
- R10: A full-page column command with an odd start column is refused. `burst_reject` pulses for one cycle and the burst state is unchanged.
- R11: A column command issued during a burst restarts the sequence from the new start column. The command wins over `burst_halt` when both arrive in the same cycle.
- R12: The auto-precharge bit given with a column command appears on `auto_pre` for the whole burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_load | input | 1 | Load strobe for the mode word |
| mode_word | input | 12 | Mode word: length, ordering, latency, test, DLL reset, reserved |
| mode_bank | input | 2 | Register select; must be zero for this register |
| burst_go | input | 1 | Column command strobe |
| burst_col | input | 8 | Starting column of the burst |
| burst_ap | input | 1 | Auto-precharge bit of the column command |
| burst_halt | input | 1 | Terminates the running burst |
| col_addr | output | 8 | Current column address (first column of a beat pair) |
| burst_active | output | 1 | An address is valid this cycle |
| burst_last | output | 1 | Final address of a fixed-length burst |
| auto_pre | output | 1 | Auto-precharge bit of the running burst |
| read_latency | output | 3 | Read latency decoded from the mode |
| mode_error | output | 1 | Last load was refused |
| dll_reset | output | 1 | One-cycle DLL reset request |
| burst_reject | output | 1 | One-cycle pulse on a refused column command |

## Verification
The tests chose the start columns so that sequential and interleaved ordering give different orders. The start 0x26 in bursts of eight is the main example. Odd starts in bursts of four show that the wrap stays inside the aligned block and does not carry into the upper bits. A full-page burst starting at 0xFC crosses the 256-column boundary, which shows the ring wrap and the absence of a last flag. Each refused mode word follows a legal one, and a burst run afterwards shows whether the old ordering and latency survived the refusal. The restart case starts a second command in the middle of a burst, which shows whether the step counter and the base column reload together.

// File: rtl/bseq_pkg.sv
// Package: shared encodings for the burst column sequencer.
// Assumes: a 3-bit length field and a 3-bit latency field in the mode word.
package bseq_pkg;

    typedef enum logic [2:0] {
        BL_TWO   = 3'b001,
        BL_FOUR  = 3'b010,
        BL_EIGHT = 3'b011,
        BL_PAGE  = 3'b111
    } bl_code_e;

    typedef struct packed {
        logic [2:0] bl;
        logic       itlv;
        logic [2:0] lat;
    } mode_t;

    localparam mode_t MODE_RESET = '{bl: 3'b001, itlv: 1'b0, lat: 3'd3};

    // Returns 1 when the length code is one of the four legal codes.
    function automatic logic bl_legal(input logic [2:0] code);
        return (code == BL_TWO) || (code == BL_FOUR) ||
               (code == BL_EIGHT) || (code == BL_PAGE);
    endfunction

endpackage

// File: rtl/bseq_mode_reg.sv
// Module: bseq_mode_reg
// Checks and stores the mode word. A refused word sets the error flag and
// keeps the old mode. An accepted word with its DLL bit set gives a
// one-cycle request.
// Assumes: bit 7 is test mode, bit 8 is DLL reset, bits above 8 are reserved.
module bseq_mode_reg
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] word_i,
    input  logic [BANK_W-1:0] bank_i,
    output mode_t             mode_o,
    output logic              err_o,
    output logic              dll_o
);
    localparam int RSV_LO = 9;

    mode_t cand;
    logic  fields_ok, combo_ok, accept;

    // Split the incoming word into mode fields and judge whether it is legal.
    always_comb begin
        cand.bl   = word_i[2:0];
        cand.itlv = word_i[3];
        cand.lat  = word_i[6:4];
        fields_ok = bl_legal(cand.bl) && (cand.lat == 3'd3 || cand.lat == 3'd4)
                    && !word_i[7] && (word_i[ADDR_W-1:RSV_LO] == '0)
                    && (bank_i == '0);
        combo_ok  = !((cand.bl == BL_PAGE) && cand.itlv);
        accept    = fields_ok && combo_ok;
    end

    // Store an accepted mode; raise the error flag on a refused load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= MODE_RESET;
            err_o  <= 1'b0;
            dll_o  <= 1'b0;
        end else begin
            dll_o <= 1'b0;
            if (load_i) begin
                if (accept) begin
                    mode_o <= cand;
                    err_o  <= 1'b0;
                    dll_o  <= word_i[8];
                end else begin
                    err_o <= 1'b1;
                end
            end
        end
    end

    // R2: the stored latency is always one of the supported values
    a_r2_lat_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o.lat == 3'd3) || (mode_o.lat == 3'd4));

    // R3: a refused load leaves the stored mode untouched
    a_r3_refuse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !accept) |=> (err_o && $stable(mode_o)));

    // R4: full page and interleaved never coexist in the stored mode
    a_r4_no_page_itlv: assert property (@(posedge clk) disable iff (!rst_n)
        !((mode_o.bl == BL_PAGE) && mode_o.itlv));

    // R5: the DLL request only follows a load in the previous cycle
    a_r5_dll_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (dll_o |-> $past(word_i[8])));

endmodule

// File: rtl/bseq_burst_ctr.sv
// Module: bseq_burst_ctr
// Steps through the beat pairs of a burst and forms each column address.
// The mode is captured when a command starts, so a later mode load does not
// disturb a burst that is running.
// Assumes: one address per cycle; each address covers two data beats.
module bseq_burst_ctr
    import bseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode_i,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             ap_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             active_o,
    output logic             last_o,
    output logic             ap_o,
    output logic             reject_o
);
    localparam int STEP_W = COL_W - 1;

    logic [COL_W-1:0]  base_q, mask_q, mask_d, off, sum;
    logic [STEP_W-1:0] step_q;
    logic              itlv_q, full_q, full_d, bad_start, take;

    // Work out the wrap mask for the current length and check the start column.
    always_comb begin
        unique case (mode_i.bl)
            BL_TWO:   mask_d = COL_W'(1);
            BL_FOUR:  mask_d = COL_W'(3);
            BL_EIGHT: mask_d = COL_W'(7);
            default:  mask_d = '1;
        endcase
        full_d    = (mode_i.bl == BL_PAGE);
        bad_start = start_i && full_d && col_i[0];
        take      = start_i && !bad_start;
    end

    // Beat-pair offset and the incremented column for sequential ordering.
    always_comb begin
        off = {step_q, 1'b0};
        sum = base_q + off;
    end

    // Each column bit: fixed outside the mask, sum or XOR inside it.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_q[b] ? (itlv_q ? (base_q[b] ^ off[b]) : sum[b])
                                    : base_q[b];
    end

    assign last_o = active_o && !full_q && (step_q == mask_q[COL_W-1:1]);

    // Burst state: start, advance, finish, halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            mask_q   <= COL_W'(1);
            step_q   <= '0;
            itlv_q   <= 1'b0;
            full_q   <= 1'b0;
            active_o <= 1'b0;
            ap_o     <= 1'b0;
            reject_o <= 1'b0;
        end else begin
            reject_o <= bad_start;
            if (take) begin
                base_q   <= col_i;
                mask_q   <= mask_d;
                itlv_q   <= mode_i.itlv;
                full_q   <= full_d;
                ap_o     <= ap_i;
                step_q   <= '0;
                active_o <= 1'b1;
            end else if (stop_i) begin
                active_o <= 1'b0;
            end else if (active_o) begin
                if (last_o) active_o <= 1'b0;
                else        step_q   <= step_q + 1'b1;
            end
        end
    end

    // R6: the last address ends the burst unless a new command arrives
    a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i && !stop_i) |=> !active_o);

    // R7: the upper column bits stay fixed inside a fixed-length burst
    a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !full_q && !last_o && !start_i && !stop_i) |=>
        ((col_o & ~mask_q) == $past(col_o & ~mask_q)));

    // R9: a full-page burst only visits even columns
    a_r9_page_even: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && full_q) |-> !col_o[0]);

    // R10: a refused command does not start an idle burst
    a_r10_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_start && !active_o) |=> (!active_o && reject_o));

    // R11: a halt without a command ends the burst
    a_r11_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !active_o);

endmodule

// File: rtl/burst_col_sequencer.sv
// Module: burst_col_sequencer (top)
// Decodes the mode word and generates the column address of each burst.
// Assumes: the mode is loaded only while no burst is running.
module burst_col_sequencer
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic [BANK_W-1:0] mode_bank,
    input  logic              burst_go,
    input  logic [COL_W-1:0]  burst_col,
    input  logic              burst_ap,
    input  logic              burst_halt,
    output logic [COL_W-1:0]  col_addr,
    output logic              burst_active,
    output logic              burst_last,
    output logic              auto_pre,
    output logic [2:0]        read_latency,
    output logic              mode_error,
    output logic              dll_reset,
    output logic              burst_reject
);
    mode_t mode;

    bseq_mode_reg #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (mode_load),
        .word_i (mode_word),
        .bank_i (mode_bank),
        .mode_o (mode),
        .err_o  (mode_error),
        .dll_o  (dll_reset)
    );

    bseq_burst_ctr #(.COL_W(COL_W)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .start_i  (burst_go),
        .col_i    (burst_col),
        .ap_i     (burst_ap),
        .stop_i   (burst_halt),
        .col_o    (col_addr),
        .active_o (burst_active),
        .last_o   (burst_last),
        .ap_o     (auto_pre),
        .reject_o (burst_reject)
    );

    assign read_latency = mode.lat;

    // R12: auto-precharge stays steady while a burst runs without a new command
    a_r12_ap_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && !burst_go) |=> $stable(auto_pre));

endmodule

// File: tb/test_burst_col_sequencer.sv
// Directed bench for burst_col_sequencer: one task per scenario.
module test_burst_col_sequencer;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       mode_load = 1'b0, burst_go = 1'b0, burst_ap = 1'b0, burst_halt = 1'b0;
    logic [11:0] mode_word = '0;
    logic [1:0]  mode_bank = '0;
    logic [7:0]  burst_col = '0;
    logic [7:0]  col_addr;
    logic        burst_active, burst_last, auto_pre, mode_error, dll_reset, burst_reject;
    logic [2:0]  read_latency;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_sequencer i_burst_col_sequencer (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .mode_bank(mode_bank), .burst_go(burst_go), .burst_col(burst_col),
        .burst_ap(burst_ap), .burst_halt(burst_halt), .col_addr(col_addr),
        .burst_active(burst_active), .burst_last(burst_last), .auto_pre(auto_pre),
        .read_latency(read_latency), .mode_error(mode_error), .dll_reset(dll_reset),
        .burst_reject(burst_reject)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Loads a mode word; samples the registered results one cycle later.
    task automatic load_mode(input logic [11:0] w, input logic [1:0] bank);
        @(negedge clk);
        mode_load = 1'b1; mode_word = w; mode_bank = bank;
        @(negedge clk);
        mode_load = 1'b0; mode_word = '0; mode_bank = '0;
    endtask

    // Issues a column command and checks n addresses packed in exp (low byte first).
    task automatic run_burst(input string req, input logic [7:0] start, input logic ap,
                             input int n, input logic [31:0] exp);
        @(negedge clk);
        burst_go = 1'b1; burst_col = start; burst_ap = ap;
        @(negedge clk);
        burst_go = 1'b0;
        for (int i = 0; i < n; i++) begin
            check({req, " active"}, burst_active, 1'b1);
            check({req, " col"}, col_addr, exp[8*i +: 8]);
            check({req, " R6 last"}, burst_last, (i == n-1));
            check({req, " R12 ap"}, auto_pre, ap);
            @(negedge clk);
        end
        check({req, " R6 ends"}, burst_active, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 err", mode_error, 0);
        check("R1 dll", dll_reset, 0);
        check("R1 active", burst_active, 0);
        check("R1 reject", burst_reject, 0);
        check("R1 col", col_addr, 0);
        check("R1 lat", read_latency, 3);
        run_burst("R1 R6 len2", 8'h41, 1'b0, 1, 32'h41);
    endtask

    task automatic t_decode();
        load_mode(12'h032, 2'd0);   // len 4, sequential, latency 3
        check("R2 lat3", read_latency, 3);
        check("R2 err", mode_error, 0);
        run_burst("R7 seq4 a", 8'h11, 1'b1, 2, 32'h1311);
        run_burst("R7 seq4 b", 8'h13, 1'b0, 2, 32'h1113);
        load_mode(12'h043, 2'd0);   // len 8, sequential, latency 4
        check("R2 lat4", read_latency, 4);
        run_burst("R7 seq8", 8'h26, 1'b0, 4, 32'h24222026);
        load_mode(12'h04B, 2'd0);   // len 8, interleaved, latency 4
        run_burst("R8 itlv8", 8'h26, 1'b1, 4, 32'h20222426);
    endtask

    task automatic t_refuse();
        load_mode(12'h034, 2'd0);   // reserved length code
        check("R3 bad len err", mode_error, 1);
        load_mode(12'h052, 2'd0);   // latency 5
        check("R3 bad lat err", mode_error, 1);
        load_mode(12'h0C3, 2'd0);   // test mode bit
        check("R3 test bit err", mode_error, 1);
        load_mode(12'h243, 2'd0);   // reserved bit 9
        check("R3 rsv bit err", mode_error, 1);
        load_mode(12'h043, 2'd1);   // nonzero bank select
        check("R3 bank err", mode_error, 1);
        load_mode(12'h03F, 2'd0);   // full page with interleaved ordering
        check("R4 page itlv err", mode_error, 1);
        check("R3 lat kept", read_latency, 4);
        run_burst("R3 R4 mode kept", 8'h26, 1'b0, 4, 32'h20222426);
    endtask

    task automatic t_dll();
        @(negedge clk);
        mode_load = 1'b1; mode_word = 12'h132; mode_bank = '0;
        @(negedge clk);
        mode_load = 1'b0; mode_word = '0;
        check("R5 dll pulse", dll_reset, 1);
        check("R5 err clear", mode_error, 0);
        check("R5 lat applied", read_latency, 3);
        @(negedge clk);
        check("R5 dll one cycle", dll_reset, 0);
        run_burst("R5 len4 applied", 8'h13, 1'b0, 2, 32'h1113);
    endtask

    task automatic t_page();
        load_mode(12'h037, 2'd0);   // full page, sequential, latency 3
        check("R2 page err", mode_error, 0);
        @(negedge clk);
        burst_go = 1'b1; burst_col = 8'hFC; burst_ap = 1'b1;
        @(negedge clk);
        burst_go = 1'b0;
        for (int i = 0; i < 5; i++) begin
            check("R9 page col", col_addr, 8'(8'hFC + 2*i));
            check("R9 page active", burst_active, 1);
            check("R9 no last", burst_last, 0);
            if (i == 4) burst_halt = 1'b1;
            @(negedge clk);
        end
        burst_halt = 1'b0;
        check("R9 halted", burst_active, 0);
        // odd start is refused while idle
        burst_go = 1'b1; burst_col = 8'h05;
        @(negedge clk);
        burst_go = 1'b0;
        check("R10 reject pulse", burst_reject, 1);
        check("R10 stays idle", burst_active, 0);
        @(negedge clk);
        check("R10 pulse one cycle", burst_reject, 0);
    endtask

    task automatic t_restart();
        load_mode(12'h043, 2'd0);
        @(negedge clk);
        burst_go = 1'b1; burst_col = 8'h26; burst_ap = 1'b0;
        @(negedge clk);
        burst_go = 1'b0;
        check("R11 first", col_addr, 8'h26);
        @(negedge clk);
        check("R11 second", col_addr, 8'h20);
        burst_go = 1'b1; burst_col = 8'h11; burst_ap = 1'b1; burst_halt = 1'b1;
        @(negedge clk);
        burst_go = 1'b0; burst_halt = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R11 restart col", col_addr, 8'(8'h11 + 2*i));
            check("R11 restart active", burst_active, 1);
            check("R12 restart ap", auto_pre, 1);
            @(negedge clk);
        end
        check("R11 ends", burst_active, 0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_refuse();
        t_dll();
        t_page();
        t_restart();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule